// File: doc/BRIEF.md
# Interrupt Acknowledge Deferral Controller

The controller decides, at every instruction boundary reported by the sequencer, whether a pending interrupt is taken. It keeps one request flag per maskable source, an edge-latched non-maskable request and the global enable flag. It picks one winner from the requesting sources. When it accepts an interrupt, it runs a fixed three-cycle save sequence: a write of the status word, a write of the program counter, then a vector load.

Some instructions touch status-word bits or interrupt configuration. The decoder tags these as deferring. A boundary at which a deferring instruction finishes never accepts an interrupt, so the earliest acceptance comes after the next instruction. A chain of deferring instructions keeps pushing acceptance back. A break instruction is not deferring, but it drops the enable flag at its boundary. A maskable request is therefore refused there, while a latched non-maskable request is still accepted.

Top module: `irq_defer_ctrl`

## Requirements
- R1: After reset, `ie_o`, `irq_pend_o`, `ack_o`, `busy_o`, `mem_we_o` and `vec_load_o` are all 0.
- R2: A pulse on `irq_req_i[i]` sets `irq_pend_o[i]` in the following cycle, whatever the mask or priority bit of that source. The flag stays set until that source is acknowledged.
- R3: A boundary (`instr_done_i`=1 while `busy_o`=0) with `instr_defer_i`=1 accepts neither maskable nor non-maskable requests. Consecutive deferring boundaries keep deferring, and the first later boundary without the tag may accept.
- R4: A maskable source is accepted at a boundary only when `ie_o`=1, its mask bit is 0, its flag is set, and both `instr_defer_i` and `instr_brk_i` are 0.
- R5: A boundary with `instr_brk_i`=1 clears `ie_o` and accepts no maskable source. A pending non-maskable request is still accepted there.
- R6: Among eligible sources, those with priority bit 1 win over those with 0. Within a group the lowest index wins, and `ack_src_o` carries that index.
- R7: A rising edge of `nmi_i` latches a non-maskable request. At a non-deferring boundary it wins over all maskable sources, whatever `ie_o` and the masks are, and `ack_nmi_o`=1 with `ack_o`.
- R8: A maskable acceptance clears the winner's flag and clears `ie_o`. A non-maskable acceptance changes neither the flags nor `ie_o`.
- R9: In the cycle after an accepting boundary, `ack_o` pulses for one cycle with `mem_we_o`=1 and `mem_wdata_o`=status word. Next comes `mem_we_o`=1 with `mem_wdata_o`=program counter, then `vec_load_o`=1. `busy_o` is 1 for exactly these three cycles.
- R10: `instr_done_i` is ignored while `busy_o`=1, so no acknowledge follows a busy cycle.
- R11: `ie_set_i` sets `ie_o` in the next cycle and `ie_clr_i` clears it. A clear, a break boundary or a maskable acceptance wins over a simultaneous set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| instr_done_i | input | 1 | Instruction-complete strobe |
| instr_defer_i | input | 1 | Finishing instruction belongs to the deferring class |
| instr_brk_i | input | 1 | Finishing instruction is a break |
| ie_set_i | input | 1 | Enable-interrupt request |
| ie_clr_i | input | 1 | Disable-interrupt request |
| irq_req_i | input | NUM_SRC | Per-source request pulses |
| irq_mask_i | input | NUM_SRC | Per-source mask (1 = masked) |
| irq_prio_i | input | NUM_SRC | Per-source priority group (1 = high) |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| status_i | input | PSW_W | Status word to save |
| pc_i | input | PC_W | Program counter to save |
| ie_o | output | 1 | Global interrupt enable flag |
| irq_pend_o | output | NUM_SRC | Per-source request flags |
| ack_o | output | 1 | Acknowledge pulse |
| ack_nmi_o | output | 1 | Acknowledged request is non-maskable |
| ack_src_o | output | clog2(NUM_SRC) | Acknowledged source index |
| busy_o | output | 1 | Save sequence running |
| mem_we_o | output | 1 | Stack write strobe |
| mem_wdata_o | output | max(PSW_W,PC_W) | Stack write data |
| vec_load_o | output | 1 | Vector load strobe |

## Verification
The assertions assume that the decoder never tags a break as deferring, so `instr_defer_i` and `instr_brk_i` are never both 1 at a boundary. They also assume that `status_i` and `pc_i` are valid in the boundary cycle. The bench drives every input at the falling edge and keeps the two instruction tags mutually exclusive. It holds `nmi_i` low across each reset so that no spurious edge is latched. During the sweep it resets the block before every pattern, so each boundary starts from a known enable and flag state.

// File: rtl/irq_defer_pkg.sv
package irq_defer_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PSW  = 2'd1,
    SEQ_PC   = 2'd2,
    SEQ_VEC  = 2'd3
  } seq_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max_width(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flag_o
);
  logic [NUM_SRC-1:0] flag_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk_i) begin
      if (rst_i) flag_q[i] <= 1'b0;
      else       flag_q[i] <= (flag_q[i] & ~clr_i[i]) | req_i[i];
    end

    // R2: a flag only rises after a request
    p_flag_needs_req_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (!flag_q[i] && !req_i[i]) |=> !flag_q[i]);
    // R2: a flag only falls on its own clear
    p_flag_holds_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_SRC-1:0] prio_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] hi_grp;
  logic [NUM_SRC-1:0] lo_grp;
  logic [NUM_SRC-1:0] win_grp;

  always_comb begin
    elig    = flag_i & ~mask_i;
    hi_grp  = elig & prio_i;
    lo_grp  = elig & ~prio_i;
    win_grp = (|hi_grp) ? hi_grp : lo_grp;
    valid_o = |win_grp;
    idx_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (win_grp[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_save_seq.sv
module irq_save_seq
  import irq_defer_pkg::*;
#(
  parameter int unsigned PSW_W  = 8,
  parameter int unsigned PC_W   = 16,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              nmi_i,
  input  logic [IDX_W-1:0]  src_i,
  input  logic [PSW_W-1:0]  psw_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              ack_o,
  output logic              ack_nmi_o,
  output logic [IDX_W-1:0]  ack_src_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              vec_load_o
);
  seq_state_e          state_q;
  logic [PC_W-1:0]     pc_q;
  logic                ack_q, nmi_q, we_q, vec_q;
  logic [IDX_W-1:0]    src_q;
  logic [DATA_W-1:0]   wdata_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= SEQ_IDLE;
      pc_q    <= '0;
      ack_q   <= 1'b0;
      nmi_q   <= 1'b0;
      src_q   <= '0;
      we_q    <= 1'b0;
      vec_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      ack_q <= 1'b0;
      we_q  <= 1'b0;
      vec_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_PSW;
            ack_q   <= 1'b1;
            nmi_q   <= nmi_i;
            src_q   <= src_i;
            pc_q    <= pc_i;
            we_q    <= 1'b1;
            wdata_q <= DATA_W'(psw_i);
          end
        end
        SEQ_PSW: begin
          state_q <= SEQ_PC;
          we_q    <= 1'b1;
          wdata_q <= DATA_W'(pc_q);
        end
        SEQ_PC: begin
          state_q <= SEQ_VEC;
          vec_q   <= 1'b1;
          wdata_q <= '0;
        end
        SEQ_VEC: state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign ack_o       = ack_q;
  assign ack_nmi_o   = nmi_q;
  assign ack_src_o   = src_q;
  assign busy_o      = (state_q != SEQ_IDLE);
  assign mem_we_o    = we_q;
  assign mem_wdata_o = wdata_q;
  assign vec_load_o  = vec_q;

  // R9: status write is followed by the counter write
  p_psw_then_pc_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == SEQ_PSW) |=> (state_q == SEQ_PC && mem_we_o));
  // R9: acknowledge lasts a single cycle
  p_ack_pulse_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |=> !ack_o);
  // R9: stack writes and vector loads only inside the busy window
  p_strobe_in_busy_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (mem_we_o || vec_load_o) |-> busy_o);
endmodule

// File: rtl/irq_defer_ctrl.sv
module irq_defer_ctrl
  import irq_defer_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned PSW_W   = 8,
  parameter int unsigned PC_W    = 16,
  localparam int unsigned IDX_W  = idx_width(NUM_SRC),
  localparam int unsigned DATA_W = max_width(PSW_W, PC_W)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               instr_done_i,
  input  logic               instr_defer_i,
  input  logic               instr_brk_i,
  input  logic               ie_set_i,
  input  logic               ie_clr_i,
  input  logic [NUM_SRC-1:0] irq_req_i,
  input  logic [NUM_SRC-1:0] irq_mask_i,
  input  logic [NUM_SRC-1:0] irq_prio_i,
  input  logic               nmi_i,
  input  logic [PSW_W-1:0]   status_i,
  input  logic [PC_W-1:0]    pc_i,
  output logic               ie_o,
  output logic [NUM_SRC-1:0] irq_pend_o,
  output logic               ack_o,
  output logic               ack_nmi_o,
  output logic [IDX_W-1:0]   ack_src_o,
  output logic               busy_o,
  output logic               mem_we_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  output logic               vec_load_o
);
  logic               ie_q;
  logic               nmi_prev_q, nmi_pend_q, nmi_edge;
  logic [NUM_SRC-1:0] flag_w, clr_w;
  logic               sel_valid;
  logic [IDX_W-1:0]   sel_idx;
  logic               boundary, nmi_take, mask_take, start;

  // Boundary decision
  always_comb begin
    boundary  = instr_done_i && !busy_o;
    nmi_take  = boundary && nmi_pend_q && !instr_defer_i;
    mask_take = boundary && !instr_defer_i && !instr_brk_i && ie_q &&
                sel_valid && !nmi_pend_q;
    start     = nmi_take || mask_take;
    clr_w     = '0;
    if (mask_take) clr_w[sel_idx] = 1'b1;
  end

  assign nmi_edge = nmi_i && !nmi_prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ie_q       <= 1'b0;
      nmi_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_i;
      nmi_pend_q <= (nmi_pend_q && !nmi_take) || nmi_edge;
      if (mask_take || (boundary && instr_brk_i) || ie_clr_i) ie_q <= 1'b0;
      else if (ie_set_i)                                       ie_q <= 1'b1;
    end
  end

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .req_i  (irq_req_i),
    .clr_i  (clr_w),
    .flag_o (flag_w)
  );

  irq_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .flag_i  (flag_w),
    .mask_i  (irq_mask_i),
    .prio_i  (irq_prio_i),
    .valid_o (sel_valid),
    .idx_o   (sel_idx)
  );

  irq_save_seq #(.PSW_W(PSW_W), .PC_W(PC_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_i     (start),
    .nmi_i       (nmi_take),
    .src_i       (sel_idx),
    .psw_i       (status_i),
    .pc_i        (pc_i),
    .ack_o       (ack_o),
    .ack_nmi_o   (ack_nmi_o),
    .ack_src_o   (ack_src_o),
    .busy_o      (busy_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .vec_load_o  (vec_load_o)
  );

  assign ie_o       = ie_q;
  assign irq_pend_o = flag_w;

  // R3: a deferring boundary never leads to an acknowledge
  p_defer_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (instr_done_i && instr_defer_i && !busy_o) |=> !ack_o);
  // R5: a break boundary never yields a maskable acknowledge
  p_brk_no_mask_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (instr_done_i && instr_brk_i && !busy_o) |=> !(ack_o && !ack_nmi_o));
  // R5: the enable is low after a break boundary
  p_brk_clears_ie_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (instr_done_i && instr_brk_i && !busy_o) |=> !ie_o);
  // R8: a maskable acknowledge comes with the enable cleared
  p_mack_clears_ie_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && !ack_nmi_o) |-> !ie_o);
  // R10: no acknowledge follows a busy cycle
  p_busy_blocks_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o |=> !ack_o);
  // R11: a disable request always wins
  p_clr_wins_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    ie_clr_i |=> !ie_o);
endmodule

// File: tb/irq_defer_ctrl_tb.sv
module irq_defer_ctrl_tb;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic instr_done = 1'b0, instr_defer = 1'b0, instr_brk = 1'b0;
  logic ie_set = 1'b0, ie_clr = 1'b0, nmi = 1'b0;
  logic [N-1:0] irq_req = '0, irq_mask = '0, irq_prio = '0;
  logic [7:0]   status = '0;
  logic [15:0]  pc = '0;
  logic         ie, ack, ack_nmi, busy, mem_we, vec_load;
  logic [N-1:0] pend;
  logic [1:0]   ack_src;
  logic [15:0]  wdata;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  irq_defer_ctrl #(.NUM_SRC(N), .PSW_W(8), .PC_W(16)) u_dut (
    .clk_i(clk), .rst_i(rst), .instr_done_i(instr_done), .instr_defer_i(instr_defer),
    .instr_brk_i(instr_brk), .ie_set_i(ie_set), .ie_clr_i(ie_clr), .irq_req_i(irq_req),
    .irq_mask_i(irq_mask), .irq_prio_i(irq_prio), .nmi_i(nmi), .status_i(status), .pc_i(pc),
    .ie_o(ie), .irq_pend_o(pend), .ack_o(ack), .ack_nmi_o(ack_nmi), .ack_src_o(ack_src),
    .busy_o(busy), .mem_we_o(mem_we), .mem_wdata_o(wdata), .vec_load_o(vec_load)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; instr_done = 0; instr_defer = 0; instr_brk = 0;
    ie_set = 0; ie_clr = 0; nmi = 0; irq_req = '0; irq_mask = '0; irq_prio = '0;
    tick();
    rst = 1'b0;
  endtask

  function automatic int exp_src(input int p, input int m, input int q);
    int e, g;
    e = p & ~m & 15;
    g = ((e & q) != 0) ? (e & q) : (e & ~q & 15);
    for (int i = 0; i < N; i++) if (g[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    tick();
    do_reset();
    // R1 reset state
    chk("R1 ie", ie, 0); chk("R1 pend", pend, 0); chk("R1 ack", ack, 0);
    chk("R1 busy", busy, 0); chk("R1 we", mem_we, 0); chk("R1 vec", vec_load, 0);

    // R4 R6 R2 R8: sweep of pattern, mask, priority
    for (int p = 0; p < 16; p++)
      for (int m = 0; m < 16; m++)
        for (int q = 0; q < 16; q++) begin
          int s;
          do_reset();
          ie_set = 1; irq_req = N'(p); irq_mask = N'(m); irq_prio = N'(q);
          tick();
          ie_set = 0; irq_req = '0; instr_done = 1;
          tick();
          instr_done = 0;
          s = exp_src(p, m, q);
          if (s >= 0) begin
            chk("R4 ack", ack, 1); chk("R6 src", ack_src, s); chk("R7 nmi flag", ack_nmi, 0);
            chk("R8 flag cleared", pend, p & ~(1 << s));
            chk("R8 ie cleared", ie, 0);
          end else begin
            chk("R4 no ack", ack, 0); chk("R2 flags kept", pend, p); chk("R4 ie kept", ie, 1);
          end
        end

    // R9 R10: save sequence and busy window
    do_reset();
    status = 8'hA5; pc = 16'h1234;
    ie_set = 1; irq_req = 4'b0100;
    tick();
    ie_set = 0; irq_req = '0; instr_done = 1;
    tick();
    chk("R9 ack", ack, 1); chk("R9 src", ack_src, 2); chk("R9 busy", busy, 1);
    chk("R9 we psw", mem_we, 1); chk("R9 psw data", wdata, 16'h00A5); chk("R9 vec0", vec_load, 0);
    ie_set = 1; irq_req = 4'b0010; status = 8'h00; pc = 16'h0000;
    tick();
    ie_set = 0; irq_req = '0;
    chk("R9 ack pulse", ack, 0); chk("R9 we pc", mem_we, 1); chk("R9 pc data", wdata, 16'h1234);
    chk("R10 busy", busy, 1);
    tick();
    chk("R9 vec", vec_load, 1); chk("R9 we off", mem_we, 0); chk("R10 no ack", ack, 0);
    tick();
    chk("R9 busy end", busy, 0); chk("R10 no ack after busy", ack, 0);
    tick();
    instr_done = 0;
    chk("R10 later ack", ack, 1); chk("R6 later src", ack_src, 1);
    repeat (3) tick();

    // R3: chained deferring boundaries
    do_reset();
    ie_set = 1; irq_req = 4'b0001;
    tick();
    ie_set = 0; irq_req = '0; instr_done = 1; instr_defer = 1;
    tick();
    chk("R3 first defer", ack, 0);
    tick();
    chk("R3 second defer", ack, 0); chk("R3 flag held", pend, 1);
    instr_defer = 0;
    tick();
    instr_done = 0;
    chk("R3 released", ack, 1); chk("R3 src", ack_src, 0);
    repeat (3) tick();

    // R5: break boundary
    do_reset();
    ie_set = 1; irq_req = 4'b1000;
    tick();
    ie_set = 0; irq_req = '0; instr_done = 1; instr_brk = 1;
    tick();
    instr_done = 0; instr_brk = 0;
    chk("R5 no mask ack", ack, 0); chk("R5 ie cleared", ie, 0); chk("R5 flag kept", pend, 8);
    nmi = 1;
    tick();
    instr_done = 1; instr_brk = 1;
    tick();
    instr_done = 0; instr_brk = 0;
    chk("R5 nmi at break", ack, 1); chk("R5 nmi kind", ack_nmi, 1); chk("R8 flags after nmi", pend, 8);
    repeat (3) tick();
    nmi = 0;

    // R7 R8: nmi precedence, enable untouched
    do_reset();
    ie_set = 1; irq_req = 4'b0010;
    tick();
    ie_set = 0; irq_req = '0; nmi = 1;
    tick();
    instr_done = 1;
    tick();
    instr_done = 0;
    chk("R7 nmi wins", ack_nmi, 1); chk("R7 ack", ack, 1);
    chk("R8 ie kept on nmi", ie, 1); chk("R8 flag kept on nmi", pend, 2);
    repeat (3) tick();
    instr_done = 1;
    tick();
    instr_done = 0;
    chk("R7 maskable next", ack, 1); chk("R7 not nmi", ack_nmi, 0); chk("R6 src after nmi", ack_src, 1);
    repeat (3) tick();
    nmi = 0;

    // R3 R7: nmi deferred, enable off and all masked
    do_reset();
    irq_mask = 4'b1111; nmi = 1;
    tick();
    instr_done = 1; instr_defer = 1;
    tick();
    chk("R3 nmi deferred", ack, 0);
    instr_defer = 0;
    tick();
    instr_done = 0;
    chk("R7 nmi taken", ack, 1); chk("R7 nmi kind", ack_nmi, 1);
    repeat (3) tick();
    nmi = 0;

    // R11: enable set and clear ordering
    do_reset();
    ie_set = 1; ie_clr = 1;
    tick();
    chk("R11 clear wins", ie, 0);
    ie_clr = 0;
    tick();
    chk("R11 set", ie, 1);
    ie_set = 0; ie_clr = 1;
    tick();
    chk("R11 clear", ie, 0);
    ie_clr = 0; ie_set = 1; irq_req = 4'b0001;
    tick();
    irq_req = '0; instr_done = 1;
    tick();
    instr_done = 0; ie_set = 0;
    chk("R11 ack beats set", ie, 0); chk("R11 ack", ack, 1);
    repeat (3) tick();

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule